// File: doc/BRIEF.md
# Synchronized Trigger Routing Crossbar

This block routes trigger signals for a timing module. There are nine output routes: six single-ended front-panel lines and three differential-pair lines. Each route picks its own source from a fixed set of trigger inputs and constants. A route can drive its pick straight to its output. It can also retime the pick through a two-stage register that advances only on the edges of a shared synchronization clock.

The synchronization clock comes from one of four reference inputs. Those inputs are an internal clock generator, a 10 MHz backplane clock, a 100 MHz backplane clock and an external clock. The block first brings the selected reference into the block clock domain. Its rising edges then become single-cycle enable pulses, called full-rate ticks. Two independent power-of-two dividers thin these ticks. Each route chooses whether it follows the full-rate tick, the first divider's tick or the second divider's tick.

Each divider is a two-state machine:
- DIV_PASS: ratio 1. Every input tick passes through.
- DIV_COUNT: ratio 2^n. The divider counts input ticks and emits one tick at the terminal count.

Transitions happen only at a terminal count. In either state the divider loads the new exponent at that point. An exponent of zero leads to DIV_PASS (PASS->PASS, COUNT->PASS). A non-zero exponent leads to DIV_COUNT (PASS->COUNT, COUNT->COUNT).

Top module: `trig_xbar`

## Requirements
- R1: The 5-bit source code of a route selects its signal as follows:
  - 0: logic 0.
  - 1: logic 1.
  - 2..7: front-panel inputs 0..5.
  - 8..10: differential-pair inputs 0..2.
  - 11..18: backplane triggers 0..7.
  - 19: star trigger.
  - 20: software trigger.
  - 21: synchronization clock level.
  - 22: differential star.
  - 23..31: logic 0.

  With synchronization off, the route drives its selected signal combinationally.
- R2: Routes 0..5 drive `fp_out[0..5]`, and routes 6..8 drive `pair_out[0..2]`. Each route's selection is independent of every other route's.
- R3: The reference select field chooses the reference input: 0 is `ref_in[0]` (generator), 1 is `ref_in[1]` (10 MHz), 2 is `ref_in[2]` (100 MHz) and 3 is `ref_in[3]` (external). The reference passes through two synchronizing flops. A full-rate tick occurs in the cycle where the synchronized level is 1 and was 0 on the previous cycle.
- R4: Divider 1 emits one tick every 2^n full-rate ticks, and divider 2 independently emits one every 2^m. Exponents above 9 are treated as 9, which gives divide by 512.
- R5: The 2-bit rate field of a route selects its tick source: 0 is full rate, 1 is divider 1, 2 is divider 2 and 3 is full rate.
- R6: On each selected tick of a synchronized route, the first stage takes the source and the second stage takes the first stage. With synchronization on, the output is the second stage, so it changes only on ticks.
- R7: A write to a route whose source code names that route's own loopback input is ignored entirely. The loopback input is code 2+k for single-ended route k and code 8+k for differential route k.
- R8: After reset, every route selects code 0 with synchronization off. Both dividers are at ratio 1 and the reference select is 0.
- R9: A new divider exponent takes effect at that divider's next terminal count.
- R10: A write with `cfg_wr` high updates a register at the clock edge.
  - Address 0..8 is route k. Its data bits are [4:0] source, [5] synchronization enable and [7:6] rate.
  - Address 9 is the clock register. Its data bits are [1:0] reference select, [5:2] divider-1 exponent and [9:6] divider-2 exponent.
  - Addresses 10..15 are ignored.
- R11: Source code 21 is the synchronized level of the selected reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 10 | Configuration write data |
| fp_in | input | 6 | Front-panel trigger inputs |
| pair_in | input | 3 | Differential-pair trigger inputs |
| bp_in | input | 8 | Backplane trigger lines |
| star_in | input | 1 | Star trigger |
| sw_trig | input | 1 | Global software trigger |
| dstar_in | input | 1 | Differential star trigger |
| ref_in | input | 4 | Reference clocks: generator, 10 MHz, 100 MHz, external |
| fp_out | output | 6 | Single-ended routed outputs |
| pair_out | output | 3 | Differential-pair routed outputs |

## Verification
The assertions check the following on every cycle:
- A synchronized output holds between ticks.
- A constant-zero route stays low.
- A loopback write leaves the route register untouched.
- The active divider exponent never exceeds 9.
- The active exponent changes only at a terminal count.

Only the bench scenarios can show the rest, by comparing all nine outputs each cycle against a behavioural model. This covers the real tick spacing for each divider ratio, including the clamp of exponents 10..15. It also covers the two-tick latency of the synchronizer, each reference choice, and the correct source bit for every code.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;
    localparam int NUM_SE    = 6;
    localparam int NUM_DIFF  = 3;
    localparam int NUM_BP    = 8;
    localparam int NUM_REF   = 4;
    localparam int NUM_ROUTE = NUM_SE + NUM_DIFF;
    localparam int SRC_W     = 5;
    localparam int NUM_CODE  = 1 << SRC_W;
    localparam int EXP_W     = 4;
    localparam int EXP_MAX   = 9;
    localparam int CNT_W     = EXP_MAX;
    localparam int CFG_AW    = 4;
    localparam int CFG_DW    = 10;
    localparam int CLK_ADDR  = NUM_ROUTE;

    localparam logic [SRC_W-1:0] SRC_ZERO  = 5'd0;
    localparam logic [SRC_W-1:0] SRC_ONE   = 5'd1;
    localparam logic [SRC_W-1:0] SRC_FP0   = 5'd2;
    localparam logic [SRC_W-1:0] SRC_PAIR0 = 5'd8;

    typedef enum logic [1:0] {
        RATE_FULL = 2'd0,
        RATE_DIV1 = 2'd1,
        RATE_DIV2 = 2'd2,
        RATE_ALT  = 2'd3
    } rate_e;

    typedef struct packed {
        rate_e            rate;
        logic             sync_en;
        logic [SRC_W-1:0] src;
    } route_cfg_t;

    function automatic logic [SRC_W-1:0] loop_code(input int route);
        if (route < NUM_SE)
            return SRC_FP0 + SRC_W'(route);
        return SRC_PAIR0 + SRC_W'(route - NUM_SE);
    endfunction
endpackage

// File: rtl/trig_clk_div.sv
module trig_clk_div
    import trig_xbar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic [EXP_W-1:0] exp_cfg,
    output logic             tick_out
);
    typedef enum logic {DIV_PASS, DIV_COUNT} div_state_e;

    div_state_e       state;
    logic [EXP_W-1:0] act_exp;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [EXP_W-1:0] next_exp;

    assign lim      = (CNT_W'(1) << act_exp) - CNT_W'(1);
    assign next_exp = (exp_cfg > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DIV_PASS;
            act_exp <= '0;
            cnt     <= '0;
        end else if (tick_out) begin
            cnt     <= '0;
            act_exp <= next_exp;
            state   <= (next_exp == '0) ? DIV_PASS : DIV_COUNT;
        end else if (tick_in) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_comb begin
        unique case (state)
            DIV_PASS:  tick_out = tick_in;
            DIV_COUNT: tick_out = tick_in && (cnt == lim);
            default:   tick_out = 1'b0;
        endcase
    end

    // R4: the active exponent never exceeds the clamp limit
    a_r4_exp_clamped: assert property (@(posedge clk) disable iff (rst)
        act_exp <= EXP_W'(EXP_MAX));

    // R9: the exponent changes only at a terminal count
    a_r9_exp_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_out |=> $stable(act_exp));
endmodule

// File: rtl/trig_sync_gen.sv
module trig_sync_gen
    import trig_xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REF-1:0] ref_in,
    input  logic [1:0]         ref_sel,
    input  logic [EXP_W-1:0]   exp1,
    input  logic [EXP_W-1:0]   exp2,
    output logic [2:0]         ticks,
    output logic               sclk_lvl
);
    logic [NUM_REF-1:0] meta_q, lvl_q, prev_q;
    logic               tick_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= ref_in;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign sclk_lvl  = lvl_q[ref_sel];
    assign tick_full = lvl_q[ref_sel] & ~prev_q[ref_sel];
    assign ticks[0]  = tick_full;

    trig_clk_div i_div1 (
        .clk(clk), .rst(rst), .tick_in(tick_full), .exp_cfg(exp1), .tick_out(ticks[1])
    );
    trig_clk_div i_div2 (
        .clk(clk), .rst(rst), .tick_in(tick_full), .exp_cfg(exp2), .tick_out(ticks[2])
    );
endmodule

// File: rtl/trig_route.sv
module trig_route
    import trig_xbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CODE-1:0] src_vec,
    input  route_cfg_t          cfg,
    input  logic [2:0]          ticks,
    output logic                out
);
    logic sel_tick;
    logic src_bit;
    logic s1_q, s2_q;

    always_comb begin
        unique case (cfg.rate)
            RATE_DIV1: sel_tick = ticks[1];
            RATE_DIV2: sel_tick = ticks[2];
            default:   sel_tick = ticks[0];
        endcase
    end

    assign src_bit = src_vec[cfg.src];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else if (sel_tick) begin
            s1_q <= src_bit;
            s2_q <= s1_q;
        end
    end

    assign out = cfg.sync_en ? s2_q : src_bit;

    // R6: a synchronized output holds when no tick was selected
    a_r6_sync_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg.sync_en && !sel_tick) && cfg.sync_en) |-> $stable(out));

    // R1: a direct constant-zero route stays low
    a_r1_zero_low: assert property (@(posedge clk) disable iff (rst)
        (!cfg.sync_en && cfg.src == SRC_ZERO) |-> !out);
endmodule

// File: rtl/trig_xbar_cfg.sv
module trig_xbar_cfg
    import trig_xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output route_cfg_t        route_o [NUM_ROUTE],
    output logic [1:0]        ref_sel_o,
    output logic [EXP_W-1:0]  exp1_o,
    output logic [EXP_W-1:0]  exp2_o
);
    route_cfg_t route_q [NUM_ROUTE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_ROUTE; k++)
                route_q[k] <= '0;
            ref_sel_o <= '0;
            exp1_o    <= '0;
            exp2_o    <= '0;
        end else if (cfg_wr) begin
            for (int k = 0; k < NUM_ROUTE; k++)
                if (cfg_addr == CFG_AW'(k) && cfg_wdata[SRC_W-1:0] != loop_code(k))
                    route_q[k] <= route_cfg_t'(cfg_wdata[7:0]);
            if (cfg_addr == CFG_AW'(CLK_ADDR)) begin
                ref_sel_o <= cfg_wdata[1:0];
                exp1_o    <= cfg_wdata[5:2];
                exp2_o    <= cfg_wdata[9:6];
            end
        end
    end

    assign route_o = route_q;

    for (genvar k = 0; k < NUM_ROUTE; k++) begin : g_chk
        // R7: a loopback selection leaves the route register unchanged
        a_r7_loop_ignored: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_addr == CFG_AW'(k) && cfg_wdata[SRC_W-1:0] == loop_code(k))
            |=> $stable(route_q[k]));
    end
endmodule

// File: rtl/trig_xbar.sv
module trig_xbar
    import trig_xbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic [NUM_SE-1:0] fp_in,
    input  logic [NUM_DIFF-1:0] pair_in,
    input  logic [NUM_BP-1:0] bp_in,
    input  logic              star_in,
    input  logic              sw_trig,
    input  logic              dstar_in,
    input  logic [NUM_REF-1:0] ref_in,
    output logic [NUM_SE-1:0] fp_out,
    output logic [NUM_DIFF-1:0] pair_out
);
    route_cfg_t           route_cfg [NUM_ROUTE];
    logic [1:0]           ref_sel;
    logic [EXP_W-1:0]     exp1, exp2;
    logic [2:0]           ticks;
    logic                 sclk_lvl;
    logic [NUM_CODE-1:0]  src_vec;
    logic [NUM_ROUTE-1:0] route_out;

    trig_xbar_cfg i_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .route_o(route_cfg), .ref_sel_o(ref_sel), .exp1_o(exp1), .exp2_o(exp2)
    );

    trig_sync_gen i_sync (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_sel(ref_sel),
        .exp1(exp1), .exp2(exp2), .ticks(ticks), .sclk_lvl(sclk_lvl)
    );

    assign src_vec = {(NUM_CODE - 23)'(0), dstar_in, sclk_lvl, sw_trig, star_in,
                      bp_in, pair_in, fp_in, 1'b1, 1'b0};

    for (genvar k = 0; k < NUM_ROUTE; k++) begin : g_route
        trig_route i_route (
            .clk(clk), .rst(rst), .src_vec(src_vec), .cfg(route_cfg[k]),
            .ticks(ticks), .out(route_out[k])
        );
    end

    assign fp_out   = route_out[NUM_SE-1:0];
    assign pair_out = route_out[NUM_ROUTE-1:NUM_SE];
endmodule

// File: tb/test_trig_xbar.sv
`timescale 1ns/1ps
module test_trig_xbar;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic [5:0] fp_in = '0;
    logic [2:0] pair_in = '0;
    logic [7:0] bp_in = '0;
    logic       star_in = 1'b0, sw_trig = 1'b0, dstar_in = 1'b0;
    logic [3:0] ref_in = '0;
    logic [5:0] fp_out;
    logic [2:0] pair_out;

    always #2 clk = ~clk;

    trig_xbar i_trig_xbar (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .fp_in(fp_in), .pair_in(pair_in), .bp_in(bp_in), .star_in(star_in),
        .sw_trig(sw_trig), .dstar_in(dstar_in), .ref_in(ref_in),
        .fp_out(fp_out), .pair_out(pair_out)
    );

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;
    string phase = "R8";
    logic [31:0] lfsr = 32'h1234_5678;

    int m_src [9], m_sync [9], m_rate [9], m_s1 [9], m_s2 [9];
    int m_refsel, m_e1, m_e2;
    int m_cnt [2], m_act [2];
    logic [3:0] h1, h2, h3;

    function automatic int self_code(int r);
        return (r < 6) ? 2 + r : 8 + r - 6;
    endfunction

    function automatic int clampe(int e);
        return (e > 9) ? 9 : e;
    endfunction

    task automatic chk(bit ok, string tag, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cyc=%0d got=%0d expected=%0d", tag, cyc, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 9; r++) begin
            m_src[r] = 0; m_sync[r] = 0; m_rate[r] = 0; m_s1[r] = 0; m_s2[r] = 0;
        end
        m_refsel = 0; m_e1 = 0; m_e2 = 0;
        m_cnt[0] = 0; m_cnt[1] = 0; m_act[0] = 0; m_act[1] = 0;
        h1 = '0; h2 = '0; h3 = '0;
    endtask

    task automatic step();
        logic [31:0] sv;
        logic tf;
        logic [1:0] fire;
        int sb [9];
        #1;
        sv = {9'b0, dstar_in, h2[m_refsel], sw_trig, star_in, bp_in, pair_in, fp_in, 1'b1, 1'b0};
        tf = h2[m_refsel] & ~h3[m_refsel];
        fire[0] = tf && (m_cnt[0] == (1 << m_act[0]) - 1);
        fire[1] = tf && (m_cnt[1] == (1 << m_act[1]) - 1);
        if (!rst) begin
            for (int r = 0; r < 9; r++) begin
                int ex, got;
                ex  = m_sync[r] ? m_s2[r] : int'(sv[m_src[r]]);
                got = (r < 6) ? int'(fp_out[r]) : int'(pair_out[r-6]);
                chk(got == ex, $sformatf("%s route%0d", phase, r), got, ex);
            end
        end
        if (rst) begin
            model_reset();
        end else begin
            for (int r = 0; r < 9; r++) begin
                logic t;
                t = (m_rate[r] == 1) ? fire[0] : (m_rate[r] == 2) ? fire[1] : tf;
                sb[r] = int'(sv[m_src[r]]);
                if (t) begin
                    m_s2[r] = m_s1[r];
                    m_s1[r] = sb[r];
                end
            end
            for (int d = 0; d < 2; d++) begin
                if (fire[d]) begin
                    m_cnt[d] = 0;
                    m_act[d] = clampe(d == 0 ? m_e1 : m_e2);
                end else if (tf) begin
                    m_cnt[d]++;
                end
            end
            h3 = h2; h2 = h1; h1 = ref_in;
            if (cfg_wr) begin
                if (cfg_addr < 9) begin
                    if (int'(cfg_wdata[4:0]) != self_code(int'(cfg_addr))) begin
                        m_src[cfg_addr]  = int'(cfg_wdata[4:0]);
                        m_sync[cfg_addr] = int'(cfg_wdata[5]);
                        m_rate[cfg_addr] = int'(cfg_wdata[7:6]);
                    end
                end else if (cfg_addr == 9) begin
                    m_refsel = int'(cfg_wdata[1:0]);
                    m_e1 = int'(cfg_wdata[5:2]);
                    m_e2 = int'(cfg_wdata[9:6]);
                end
            end
        end
        @(negedge clk);
        cyc++;
        ref_in[0] = ((cyc / 3) % 2) != 0;
        ref_in[1] = ((cyc / 5) % 2) != 0;
        ref_in[2] = ((cyc / 2) % 2) != 0;
        ref_in[3] = ((cyc / 7) % 2) != 0;
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        fp_in = lfsr[5:0]; pair_in = lfsr[8:6]; bp_in = lfsr[16:9];
        star_in = lfsr[17]; sw_trig = lfsr[18]; dstar_in = lfsr[19];
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int addr, int data);
        cfg_wr = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 10'(data);
        step();
        cfg_wr = 1'b0;
    endtask

    function automatic int rw(int src, int sync, int rate);
        return (rate << 6) | (sync << 5) | src;
    endfunction

    function automatic int cw(int sel, int e1, int e2);
        return (e2 << 6) | (e1 << 2) | sel;
    endfunction

    initial begin
        model_reset();
        @(negedge clk);
        run(4);
        rst = 1'b0;
        // R8: reset state, all routes constant zero
        chk(fp_out == 6'd0, "R8 fp_out after reset", int'(fp_out), 0);
        chk(pair_out == 3'd0, "R8 pair_out after reset", int'(pair_out), 0);
        phase = "R8";
        run(20);

        // R1 R2 R11 R10: direct routing of many codes, reserved codes included
        phase = "R1 R2 R11 R10";
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 9; r++) begin
                int c;
                c = (r * 3 + k * 5 + 1) % 26;
                if (c == self_code(r)) c = 1;
                wr(r, rw(c, 0, 0));
            end
            wr(10 + k % 6, 10'h3ff);
            run(30);
        end

        // R3 R6: each reference, synchronized at full rate
        phase = "R3 R6";
        for (int s = 0; s < 4; s++) begin
            wr(9, cw(s, 0, 0));
            for (int r = 0; r < 9; r++) wr(r, rw((r + s) % 6 == r ? 21 : 2 + (r + s) % 6, 1, 0));
            run(150);
        end

        // R5 R4: mixed rates with distinct divider ratios
        phase = "R5 R4";
        wr(9, cw(2, 2, 5));
        for (int r = 0; r < 9; r++) wr(r, rw(11 + r % 8, 1, r % 4));
        run(2500);

        // R4: exponent above nine clamps to divide by 512
        phase = "R4 clamp";
        wr(9, cw(2, 15, 9));
        wr(0, rw(11, 1, 1));
        wr(1, rw(12, 1, 2));
        run(12000);

        // R9: divider changes mid-count take effect at terminal count
        phase = "R9";
        wr(9, cw(0, 3, 1));
        for (int r = 0; r < 9; r++) wr(r, rw(13, 1, 1 + r % 2));
        for (int j = 0; j < 20; j++) begin
            wr(9, (j % 2 == 0) ? cw(0, 1, 4) : cw(0, 3, 0));
            run(39);
        end

        // R7: loopback selections are ignored
        phase = "R7";
        wr(0, rw(1, 0, 0));
        wr(0, rw(2, 0, 0));
        run(5);
        chk(fp_out[0] == 1'b1, "R7 fp route0 kept const1", int'(fp_out[0]), 1);
        wr(7, rw(1, 0, 0));
        wr(7, rw(9, 0, 0));
        run(5);
        chk(pair_out[1] == 1'b1, "R7 pair route1 kept const1", int'(pair_out[1]), 1);
        wr(0, rw(0, 0, 0));
        run(2);
        chk(fp_out[0] == 1'b0, "R10 route0 accepts const0", int'(fp_out[0]), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired phase=%s got=%0d expected=%0d", phase, 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule